// File: doc/BRIEF.md
# Masked Interrupt Pending Controller

This block gathers interrupt requests from up to eight device lines into a pending vector and drives a single interrupt line upstream. Devices raise and drop requests through two bit-vector inputs, one that sets pending bits and one that clears them. Software controls which lines may reach the output through a mask register where a written 1 blocks a line. It retires a request by writing the line number to an acknowledge location.

A two-state line tracker (`LINE_IDLE`, `LINE_RAISED`) drives the output. It moves from `LINE_IDLE` to `LINE_RAISED` on the transition `TR_ASSERT`, taken in any cycle where the next pending vector ANDed with the next enable vector is nonzero. It moves back on `TR_RELEASE` when that product becomes zero. In all other cycles it holds, so a set, clear, acknowledge or mask write that does not change the product creates no extra assert or release event. The output follows the tracker one clock edge after the causing input.

Software uses a byte-wide register port with addresses 0 (primary mask), 1 (secondary mask), 2 (primary status), 3 (secondary status) and 4 (acknowledge, write only). Reads return their result one cycle later on a 64-bit data bus, together with a valid strobe and an error flag. The secondary mask exists so that code written for a cascaded pair of controllers keeps working, but it never affects the interrupt.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A write to address 0 stores the inverse of the written byte as the enable vector, so a 1 written blocks that line. A byte read of address 0 returns the byte last written.
- R2: A nonzero `dev_set` ORs into the pending vector. If any pending bit is then enabled, `irq` is 1 after the next clock edge.
- R3: `dev_clr` clears the pending bits where it is 1. If no enabled pending bit remains, `irq` is 0 after the next clock edge.
- R4: A write to address 4 clears the pending bit given by bits [3:0] of the written byte, and bits [7:4] are ignored. Index values 8 to 15 leave the pending vector and `irq` unchanged.
- R5: A mask write re-evaluates the output. Unmasking a pending line raises `irq`, and masking every pending line drops it, one edge after the write.
- R6: When `dev_set` and `dev_clr` both carry the same bit in one cycle, the clear is applied after the set and the bit ends up not pending.
- R7: A read with `reg_rd`=1 returns `rd_valid`=1 on the next cycle. A status read at address 2 returns the pending vector zero-extended to 64 bits, both for byte size (`rd_size`=00) and for 64-bit size (`rd_size`=11).
- R8: A read gives `rd_err`=1 and `rd_data`=0 in any of these cases: `rd_size` is 01 or 10, a 64-bit read targets any address other than 2, or a byte read targets address 4 to 7. Writes to addresses 2, 3, 5, 6 and 7 have no effect.
- R9: Address 1 stores a mask byte that a byte read returns unchanged. That mask never affects `irq`, and a byte read of address 3 always returns 0.
- R10: After reset the pending vector is 0, `irq` is 0, and every line is blocked: a read of address 0 returns 0xFF.
- R11: `irq` rises only in the cycle after a device set or a write to address 0. It falls only in the cycle after a device clear, an acknowledge or a write to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 8 | Per-line request set vector |
| dev_clr | input | 8 | Per-line request clear vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| rd_size | input | 2 | Read size: 00 byte, 11 64-bit, others illegal |
| rd_valid | output | 1 | Read response valid, one cycle after `reg_rd` |
| rd_data | output | 64 | Read response data |
| rd_err | output | 1 | Read response error |
| irq | output | 1 | Interrupt request to the upstream chip |

## Verification
If the tracker state drifts from the masked pending product, `irq` shows it on the next edge, either as a missed assertion after a set or as a line that stays high after the last enabled bit is cleared. A wrong pending or enable bit stays hidden until the next event on that line, so the bench reads status and mask back often. Random ordering of sets, clears, acknowledges and mask writes makes such hidden errors show at `irq` within a few cycles. Read decode faults appear as a wrong value, or as a wrong error flag, one cycle after the read strobe.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] ADR_MASK_A = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADR_MASK_B = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADR_STAT_A = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADR_STAT_B = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADR_ACK    = 3'd4;

    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_DWORD = 2'b11;

    typedef enum logic {
        LINE_IDLE   = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_t;
endpackage

// File: rtl/ipc_pending.sv
module ipc_pending #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_vec,
    input  logic                 ack_fire,
    input  logic [3:0]           ack_idx,
    output logic [NUM_LINES-1:0] pend_d,
    output logic [NUM_LINES-1:0] pend_q
);
    logic [NUM_LINES-1:0] ack_hit;

    // per line: set first, then device clear, then acknowledge
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign ack_hit[i] = ack_fire && (ack_idx == 4'(i));
        assign pend_d[i]  = (pend_q[i] | set_vec[i]) & ~clr_vec[i] & ~ack_hit[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/ipc_mask.sv
module ipc_mask #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_a,
    input  logic                 wr_b,
    input  logic [7:0]           wdata,
    output logic [NUM_LINES-1:0] en_a_d,
    output logic [NUM_LINES-1:0] en_a_q,
    output logic [NUM_LINES-1:0] en_b_q
);
    // a written 1 blocks a line, so the stored enable is the inverse
    assign en_a_d = wr_a ? ~wdata[NUM_LINES-1:0] : en_a_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_a_q <= '0;
            en_b_q <= '0;
        end else begin
            en_a_q <= en_a_d;
            if (wr_b) en_b_q <= ~wdata[NUM_LINES-1:0];
        end
    end
endmodule

// File: rtl/ipc_rdmux.sv
module ipc_rdmux
    import ipc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [1:0]            size,
    input  logic [NUM_LINES-1:0]  pend,
    input  logic [NUM_LINES-1:0]  en_a,
    input  logic [NUM_LINES-1:0]  en_b,
    output logic [63:0]           data,
    output logic                  err
);
    localparam int PAD_W = 64 - NUM_LINES;

    always_comb begin
        data = '0;
        err  = 1'b0;
        if (size == SZ_DWORD) begin
            if (addr == ADR_STAT_A) data = {{PAD_W{1'b0}}, pend};
            else                    err  = 1'b1;
        end else if (size == SZ_BYTE) begin
            case (addr)
                ADR_MASK_A: data = {{PAD_W{1'b0}}, ~en_a};
                ADR_MASK_B: data = {{PAD_W{1'b0}}, ~en_b};
                ADR_STAT_A: data = {{PAD_W{1'b0}}, pend};
                ADR_STAT_B: data = '0;
                default:    err  = 1'b1;
            endcase
        end else begin
            err = 1'b1;
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import ipc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  dev_set,
    input  logic [NUM_LINES-1:0]  dev_clr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [7:0]            reg_wdata,
    input  logic [1:0]            rd_size,
    output logic                  rd_valid,
    output logic [63:0]           rd_data,
    output logic                  rd_err,
    output logic                  irq
);
    logic                 wr_mask_a, wr_mask_b, wr_ack;
    logic [NUM_LINES-1:0] pend_d, pend_q;
    logic [NUM_LINES-1:0] en_a_d, en_a_q, en_b_q;
    logic [63:0]          mux_data;
    logic                 mux_err;
    logic                 live;
    line_state_t          state_q, state_d;

    assign wr_mask_a = reg_wr && (reg_addr == ADR_MASK_A);
    assign wr_mask_b = reg_wr && (reg_addr == ADR_MASK_B);
    assign wr_ack    = reg_wr && (reg_addr == ADR_ACK);

    ipc_pending #(.NUM_LINES(NUM_LINES)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (dev_set),
        .clr_vec  (dev_clr),
        .ack_fire (wr_ack),
        .ack_idx  (reg_wdata[3:0]),
        .pend_d   (pend_d),
        .pend_q   (pend_q)
    );

    ipc_mask #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_a   (wr_mask_a),
        .wr_b   (wr_mask_b),
        .wdata  (reg_wdata),
        .en_a_d (en_a_d),
        .en_a_q (en_a_q),
        .en_b_q (en_b_q)
    );

    ipc_rdmux #(.NUM_LINES(NUM_LINES)) u_rdmux (
        .addr (reg_addr),
        .size (rd_size),
        .pend (pend_q),
        .en_a (en_a_q),
        .en_b (en_b_q),
        .data (mux_data),
        .err  (mux_err)
    );

    // line tracker: next-state decision
    assign live = |(pend_d & en_a_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_IDLE:   if (live)  state_d = LINE_RAISED; // TR_ASSERT
            LINE_RAISED: if (!live) state_d = LINE_IDLE;   // TR_RELEASE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        irq = (state_q == LINE_RAISED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_err   <= 1'b0;
        end else begin
            rd_valid <= reg_rd;
            rd_data  <= reg_rd ? mux_data : '0;
            rd_err   <= reg_rd && mux_err;
        end
    end
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LINES-1:0]  dev_set,
    input logic [NUM_LINES-1:0]  dev_clr,
    input logic                  reg_wr,
    input logic                  reg_rd,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [7:0]            reg_wdata,
    input logic                  rd_valid,
    input logic [63:0]           rd_data,
    input logic                  rd_err,
    input logic                  irq,
    input logic [NUM_LINES-1:0]  pend_q,
    input logic [NUM_LINES-1:0]  en_a_q
);
    logic mask_wr, ack_wr, ack_low;
    assign mask_wr = reg_wr && (reg_addr == ADR_MASK_A);
    assign ack_wr  = reg_wr && (reg_addr == ADR_ACK);
    assign ack_low = ack_wr && (reg_wdata[3] == 1'b0)
                     && !dev_set[reg_wdata[2:0]];

    assert_irq_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(pend_q & en_a_q));

    assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|dev_set || mask_wr));

    assert_irq_fall_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(|dev_clr || mask_wr || ack_wr));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_low |=> (pend_q[$past(reg_wdata[2:0])] == 1'b0));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        |(dev_set & dev_clr) |=> ((pend_q & $past(dev_set & dev_clr)) == '0));

    assert_rd_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rd_valid);

    assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !rd_valid);

    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_valid && rd_data == 64'd0));
endmodule

bind irq_pend_ctrl ipc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_set   (dev_set),
    .dev_clr   (dev_clr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .irq       (irq),
    .pend_q    (pend_q),
    .en_a_q    (en_a_q)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  dev_set = '0, dev_clr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  rd_size = '0;
    logic        rd_valid, rd_err, irq;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [7:0] m_pend = '0, m_en_a = '0, m_en_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_pend_ctrl u_irq_pend_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_set(dev_set), .dev_clr(dev_clr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rd_size(rd_size), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_err(rd_err), .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        return |(m_pend & m_en_a);
    endfunction

    function automatic logic [64:0] exp_read(input logic [2:0] a, input logic [1:0] s);
        if (s == 2'b11) return (a == 3'd2) ? {1'b0, 56'd0, m_pend} : {1'b1, 64'd0};
        if (s != 2'b00) return {1'b1, 64'd0};
        case (a)
            3'd0:    return {1'b0, 56'd0, ~m_en_a};
            3'd1:    return {1'b0, 56'd0, ~m_en_b};
            3'd2:    return {1'b0, 56'd0, m_pend};
            3'd3:    return 65'd0;
            default: return {1'b1, 64'd0};
        endcase
    endfunction

    // one cycle: drive at negedge, edge, update model, sample at next negedge
    task automatic step(input logic [7:0] s, input logic [7:0] c,
                        input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic r, input logic [1:0] sz, input string req);
        logic [64:0] er;
        er = exp_read(a, sz);
        dev_set = s; dev_clr = c; reg_wr = w; reg_addr = a;
        reg_wdata = d; reg_rd = r; rd_size = sz;
        @(posedge clk);
        m_pend = (m_pend | s) & ~c;
        if (w) begin
            case (a)
                3'd0: m_en_a = ~d;
                3'd1: m_en_b = ~d;
                3'd4: if (!d[3]) m_pend[d[2:0]] = 1'b0;
                default: ;
            endcase
        end
        @(negedge clk);
        dev_set = '0; dev_clr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        check(irq == exp_irq(), {req, " irq"}, 64'(irq), 64'(exp_irq()));
        if (r) begin
            check(rd_valid == 1'b1, {req, " rd_valid"}, 64'(rd_valid), 64'd1);
            check(rd_err == er[64], {req, " rd_err"}, 64'(rd_err), 64'(er[64]));
            check(rd_data == er[63:0], {req, " rd_data"}, rd_data, er[63:0]);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] sz, input string req);
        step('0, '0, 1'b0, a, 8'h00, 1'b1, sz, req);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
        step('0, '0, 1'b1, a, d, 1'b0, 2'b00, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check(irq == 1'b0, "R10 irq after reset", 64'(irq), 64'd0);
        rd(3'd0, 2'b00, "R10 mask reads FF");
        rd(3'd2, 2'b00, "R10 status zero");

        // R2: set on a blocked line does not raise
        step(8'h08, '0, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R2 blocked set");
        // R5/R1: unmask line 3
        wr(3'd0, 8'hF7, "R5 unmask raises");
        rd(3'd0, 2'b00, "R1 mask readback");
        // R7: status both sizes
        rd(3'd2, 2'b00, "R7 status byte");
        rd(3'd2, 2'b11, "R7 status dword");
        // R4: upper nibble ignored
        wr(3'd4, 8'h13, "R4 ack idx 3");
        rd(3'd2, 2'b00, "R4 status after ack");
        // R2 then R4 out-of-range index
        step(8'h08, '0, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R2 set raises");
        wr(3'd4, 8'h0B, "R4 idx 11 no effect");
        rd(3'd2, 2'b00, "R4 status kept");
        // R5: mask all, unmask all
        wr(3'd0, 8'hFF, "R5 mask drops");
        wr(3'd0, 8'h00, "R5 unmask raises again");
        // R3: device clear
        step('0, 8'h08, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R3 clear drops");
        // R6: same bit set and clear
        step(8'h21, 8'h20, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R6 clear wins");
        rd(3'd2, 2'b00, "R6 status");
        step('0, 8'h01, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R3 clear rest");
        // R8: error cases and ignored writes
        rd(3'd2, 2'b01, "R8 half size");
        rd(3'd2, 2'b10, "R8 word size");
        rd(3'd0, 2'b11, "R8 dword on mask");
        rd(3'd4, 2'b00, "R8 read ack addr");
        rd(3'd6, 2'b00, "R8 read unused");
        wr(3'd2, 8'hFF, "R8 status write ignored");
        wr(3'd7, 8'hFF, "R8 unused write ignored");
        rd(3'd2, 2'b00, "R8 status unchanged");
        rd(3'd0, 2'b00, "R8 mask unchanged");
        // R9: secondary mask
        wr(3'd1, 8'h5A, "R9 mask B write");
        rd(3'd1, 2'b00, "R9 mask B readback");
        step(8'h04, '0, 1'b0, 3'd0, 8'h00, 1'b0, 2'b00, "R9 set with B");
        wr(3'd1, 8'h00, "R9 mask B no irq effect");
        rd(3'd3, 2'b00, "R9 status B zero");
        wr(3'd0, 8'hFF, "R9 primary masks all");

        // R11 and mixed: constrained random
        for (int i = 0; i < 600; i++) begin
            logic [7:0] s, c, d;
            logic [2:0] a;
            logic [1:0] sz;
            logic w, r;
            s  = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            c  = ($urandom % 4 == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            w  = ($urandom % 3 == 0);
            r  = !w && ($urandom % 2 == 0);
            a  = 3'($urandom % 8);
            if (w && ($urandom % 2 == 0)) a = ($urandom % 2 == 0) ? 3'd0 : 3'd4;
            d  = 8'($urandom);
            sz = ($urandom % 5 == 0) ? 2'($urandom) : (($urandom % 2 == 0) ? 2'b11 : 2'b00);
            if (r && ($urandom % 2 == 0)) begin a = 3'd2; end
            step(s, c, w, a, d, r, sz, "R11 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule